// File: doc/BRIEF.md
# Dual-Width Byte FIFO Pair with Interrupt Flags

This block holds the byte storage that sits between a serial shift engine and the register bus of a serial peripheral controller. One FIFO carries transmit bytes from the bus to the engine. The other carries received bytes from the engine to the bus. The bus reaches each FIFO through two windows at separate addresses. A word window moves four bytes per access, with the least significant byte first. A byte window moves one byte per access.

The block also owns the interrupt status, enable and clear registers. Most status bits track FIFO levels: a level bit is set while its condition holds, and after a clear it comes back on the next cycle if the condition is still true. Software can therefore clear a level bit and then read it to learn the current level. Two further bits latch events: the engine's completion pulse and any illegal window access.

The interrupt output is level-high. It stays high while any enabled status bit is set.

Top module: `dwf_top`

## Requirements
- R1: A bus write to 0x20 pushes four bytes into the transmit FIFO with write data bits 7:0 first. The engine receives them on `txByte` in that order, one per `txPop` pulse.
- R2: A bus write to 0x24 pushes only write data bits 7:0 as one transmit byte. The upper bits are discarded.
- R3: A bus read of 0x28 returns the four oldest receive bytes, the oldest in bits 7:0, and removes them. A read of 0x2C returns the oldest byte in bits 7:0 with zero upper bits and removes it.
- R4: An illegal window access is dropped and sets status bit 12. A read of an illegal access returns 0. The illegal accesses are:
  - a word write with fewer than 4 free transmit bytes;
  - a byte write with no free transmit byte;
  - a word read with fewer than 4 receive bytes;
  - a byte read of an empty receive FIFO.
- R5: The level bits of the status register at 0x30 become set one cycle after their condition holds. With the default depth of 64 and marks of 16, the conditions are:
  - bit 0: transmit level at most 16;
  - bit 1: transmit FIFO empty;
  - bit 2: transmit level at least 32;
  - bit 3: transmit FIFO full (64 bytes);
  - bit 5: receive level at least 16;
  - bit 6: receive level at least 4;
  - bit 7: receive level at least 32;
  - bit 8: receive FIFO full (64 bytes);
  - bit 11: receive level at least 1.
- R6: Status bits are sticky. Writing 1s to 0x38 clears the matching bits. A level bit whose condition still holds reads 1 again from the next cycle. A bit whose condition has ended stays 0.
- R7: A pulse on `doneEvt` sets status bit 9. The bit stays set until it is cleared through 0x38.
- R8: The enable register at 0x34 reads back its write data masked to the implemented bits (mask 0x1BEF). `irq` is high exactly while some status bit and its enable bit are both 1.
- R9: A `softRst` pulse empties both FIFOs and makes the status register read 0 in the following cycle. Level bits reappear one cycle later. The enable register keeps its value.
- R10: A `txPop` with an empty transmit FIFO and an `rxPush` with a full receive FIFO are ignored. `txAvail` reports a non-empty transmit FIFO and `rxRoom` reports a non-full receive FIFO.
- R11: After reset the status register reads 0x3 (transmit empty and low), the enable register reads 0, `irq` is low, `txAvail` is 0 and `rxRoom` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Synchronous flush of both FIFOs and of the status register |
| busWr | input | 1 | Bus write strobe, one cycle per access |
| busRd | input | 1 | Bus read strobe, one cycle per access |
| busAddr | input | 8 | Bus byte address |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Bus read data, valid in the cycle `busRd` is high |
| txPop | input | 1 | Engine takes the head transmit byte |
| txByte | output | 8 | Head transmit byte |
| txAvail | output | 1 | Transmit FIFO is not empty |
| rxPush | input | 1 | Engine delivers a received byte |
| rxByte | input | 8 | Received byte |
| rxRoom | output | 1 | Receive FIFO is not full |
| doneEvt | input | 1 | Engine completion pulse |
| irq | output | 1 | Level-high interrupt |

## Verification
A wrong pointer or level count shows up at the ports as misordered bytes on `txByte` or in word reads. It also shows up as a window access that is accepted or refused on the wrong side of a boundary. The symptom appears at the first access after the fault, so FIFOs are filled to exactly full and drained to exactly empty. A bad status register shows as a status read that misses or keeps a bit, or as `irq` following it one cycle late. Each status check is therefore placed two cycles after the level change that causes it.

// File: rtl/dwf_pkg.sv
package dwf_pkg;
  localparam int AddrW = 8;

  // window and register offsets
  localparam logic [AddrW-1:0] AddrTxWord = 8'h20;
  localparam logic [AddrW-1:0] AddrTxByte = 8'h24;
  localparam logic [AddrW-1:0] AddrRxWord = 8'h28;
  localparam logic [AddrW-1:0] AddrRxByte = 8'h2C;
  localparam logic [AddrW-1:0] AddrStatus = 8'h30;
  localparam logic [AddrW-1:0] AddrEnable = 8'h34;
  localparam logic [AddrW-1:0] AddrClear  = 8'h38;

  // status bit positions
  localparam int BitTxLow   = 0;
  localparam int BitTxEmpty = 1;
  localparam int BitTxHalf  = 2;
  localparam int BitTxFull  = 3;
  localparam int BitRxHigh  = 5;
  localparam int BitRxWord  = 6;
  localparam int BitRxHalf  = 7;
  localparam int BitRxFull  = 8;
  localparam int BitDone    = 9;
  localparam int BitRxByte  = 11;
  localparam int BitIllegal = 12;

  localparam logic [31:0] ImplMask = 32'h0000_1BEF;

  // strobes from control to datapath
  typedef struct packed {
    logic       flush;
    logic [2:0] txPushCnt;
    logic       txPopOne;
    logic       rxPushOne;
    logic [2:0] rxPopCnt;
  } fifo_strobe_t;
endpackage

// File: rtl/dwf_byte_fifo.sv
module dwf_byte_fifo #(
  parameter int Depth     = 64,
  parameter int HeadBytes = 4,
  localparam int PtrW = $clog2(Depth),
  localparam int LvlW = PtrW + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   flush,
  input  logic [2:0]             pushCnt,
  input  logic [31:0]            pushData,
  input  logic [2:0]             popCnt,
  output logic [LvlW-1:0]        level,
  output logic [8*HeadBytes-1:0] headData
);
  logic [7:0]      mem [Depth];
  logic [PtrW-1:0] wrPtr, rdPtr;
  logic [LvlW-1:0] levelQ;

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (!flush && (3'(k) < pushCnt)) begin
        mem[wrPtr + PtrW'(k)] <= pushData[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      levelQ <= '0;
    end else if (flush) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      levelQ <= '0;
    end else begin
      wrPtr  <= wrPtr + PtrW'(pushCnt);
      rdPtr  <= rdPtr + PtrW'(popCnt);
      levelQ <= levelQ + LvlW'(pushCnt) - LvlW'(popCnt);
    end
  end

  for (genvar g = 0; g < HeadBytes; g++) begin : g_head
    assign headData[8*g +: 8] = mem[rdPtr + PtrW'(g)];
  end

  assign level = levelQ;
endmodule

// File: rtl/dwf_datapath.sv
module dwf_datapath
  import dwf_pkg::*;
#(
  parameter int TxDepth = 64,
  parameter int RxDepth = 64,
  localparam int TxLvlW = $clog2(TxDepth) + 1,
  localparam int RxLvlW = $clog2(RxDepth) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifo_strobe_t      strobes,
  input  logic [31:0]       busWdata,
  input  logic [7:0]        rxByte,
  output logic [TxLvlW-1:0] txLevel,
  output logic [RxLvlW-1:0] rxLevel,
  output logic [7:0]        txHead,
  output logic [31:0]       rxHead
);
  dwf_byte_fifo #(.Depth(TxDepth), .HeadBytes(1)) u_txFifo (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobes.flush),
    .pushCnt  (strobes.txPushCnt),
    .pushData (busWdata),
    .popCnt   ({2'b00, strobes.txPopOne}),
    .level    (txLevel),
    .headData (txHead)
  );

  dwf_byte_fifo #(.Depth(RxDepth), .HeadBytes(4)) u_rxFifo (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobes.flush),
    .pushCnt  ({2'b00, strobes.rxPushOne}),
    .pushData ({24'h0, rxByte}),
    .popCnt   (strobes.rxPopCnt),
    .level    (rxLevel),
    .headData (rxHead)
  );
endmodule

// File: rtl/dwf_control.sv
module dwf_control
  import dwf_pkg::*;
#(
  parameter int TxDepth = 64,
  parameter int RxDepth = 64,
  parameter int TxMark  = 16,
  parameter int RxMark  = 16,
  localparam int TxLvlW = $clog2(TxDepth) + 1,
  localparam int RxLvlW = $clog2(RxDepth) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [AddrW-1:0]  busAddr,
  input  logic [31:0]       busWdata,
  input  logic              txPop,
  input  logic              rxPush,
  input  logic              doneEvt,
  input  logic [TxLvlW-1:0] txLevel,
  input  logic [RxLvlW-1:0] rxLevel,
  input  logic [31:0]       rxHead,
  output fifo_strobe_t      strobes,
  output logic [31:0]       busRdata,
  output logic [31:0]       statusVec,
  output logic              irq,
  output logic              txAvail,
  output logic              rxRoom
);
  logic [31:0]       statusQ, enableQ, condVec, clrMask;
  logic [TxLvlW-1:0] txFree;
  logic              wrTxWord, wrTxByte, rdRxWord, rdRxByte;
  logic              txWordOk, txByteOk, rxWordOk, rxByteOk, illegal;

  assign txFree   = TxLvlW'(TxDepth) - txLevel;
  assign txWordOk = txFree >= TxLvlW'(4);
  assign txByteOk = txFree != '0;
  assign rxWordOk = rxLevel >= RxLvlW'(4);
  assign rxByteOk = rxLevel != '0;

  assign wrTxWord = busWr && (busAddr == AddrTxWord);
  assign wrTxByte = busWr && (busAddr == AddrTxByte);
  assign rdRxWord = busRd && (busAddr == AddrRxWord);
  assign rdRxByte = busRd && (busAddr == AddrRxByte);

  assign illegal = (wrTxWord && !txWordOk) || (wrTxByte && !txByteOk) ||
                   (rdRxWord && !rxWordOk) || (rdRxByte && !rxByteOk);

  always_comb begin
    strobes           = '0;
    strobes.flush     = softRst;
    strobes.txPushCnt = (wrTxWord && txWordOk) ? 3'd4 :
                        (wrTxByte && txByteOk) ? 3'd1 : 3'd0;
    strobes.txPopOne  = txPop && txAvail;
    strobes.rxPushOne = rxPush && rxRoom;
    strobes.rxPopCnt  = (rdRxWord && rxWordOk) ? 3'd4 :
                        (rdRxByte && rxByteOk) ? 3'd1 : 3'd0;
  end

  always_comb begin
    condVec             = '0;
    condVec[BitTxLow]   = txLevel <= TxLvlW'(TxMark);
    condVec[BitTxEmpty] = txLevel == '0;
    condVec[BitTxHalf]  = txLevel >= TxLvlW'(TxDepth / 2);
    condVec[BitTxFull]  = txLevel == TxLvlW'(TxDepth);
    condVec[BitRxHigh]  = rxLevel >= RxLvlW'(RxMark);
    condVec[BitRxWord]  = rxWordOk;
    condVec[BitRxHalf]  = rxLevel >= RxLvlW'(RxDepth / 2);
    condVec[BitRxFull]  = rxLevel == RxLvlW'(RxDepth);
    condVec[BitRxByte]  = rxByteOk;
    condVec[BitDone]    = doneEvt;
    condVec[BitIllegal] = illegal;
  end

  assign clrMask = (busWr && (busAddr == AddrClear)) ? busWdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
    end else begin
      if (softRst) statusQ <= '0;
      else         statusQ <= ((statusQ & ~clrMask) | condVec) & ImplMask;
      if (busWr && (busAddr == AddrEnable)) enableQ <= busWdata & ImplMask;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      case (busAddr)
        AddrStatus: busRdata = statusQ;
        AddrEnable: busRdata = enableQ;
        AddrRxWord: busRdata = rxWordOk ? rxHead : '0;
        AddrRxByte: busRdata = rxByteOk ? {24'h0, rxHead[7:0]} : '0;
        default:    busRdata = '0;
      endcase
    end
  end

  assign statusVec = statusQ;
  assign irq       = |(statusQ & enableQ);
  assign txAvail   = txLevel != '0;
  assign rxRoom    = rxLevel != RxLvlW'(RxDepth);
endmodule

// File: rtl/dwf_top.sv
module dwf_top
  import dwf_pkg::*;
#(
  parameter int TxDepth = 64,
  parameter int RxDepth = 64,
  parameter int TxMark  = 16,
  parameter int RxMark  = 16,
  localparam int TxLvlW = $clog2(TxDepth) + 1,
  localparam int RxLvlW = $clog2(RxDepth) + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        softRst,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        txPop,
  output logic [7:0]  txByte,
  output logic        txAvail,
  input  logic        rxPush,
  input  logic [7:0]  rxByte,
  output logic        rxRoom,
  input  logic        doneEvt,
  output logic        irq
);
  fifo_strobe_t      strobes;
  logic [TxLvlW-1:0] txLevel;
  logic [RxLvlW-1:0] rxLevel;
  logic [31:0]       rxHead;
  logic [31:0]       statusVec;

  dwf_control #(
    .TxDepth(TxDepth), .RxDepth(RxDepth), .TxMark(TxMark), .RxMark(RxMark)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .txPop(txPop), .rxPush(rxPush), .doneEvt(doneEvt),
    .txLevel(txLevel), .rxLevel(rxLevel), .rxHead(rxHead),
    .strobes(strobes), .busRdata(busRdata), .statusVec(statusVec),
    .irq(irq), .txAvail(txAvail), .rxRoom(rxRoom)
  );

  dwf_datapath #(.TxDepth(TxDepth), .RxDepth(RxDepth)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata),
    .rxByte(rxByte), .txLevel(txLevel), .rxLevel(rxLevel),
    .txHead(txByte), .rxHead(rxHead)
  );
endmodule

// File: rtl/dwf_checker.sv
module dwf_checker
  import dwf_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        softRst,
  input logic        busWr,
  input logic        busRd,
  input logic [7:0]  busAddr,
  input logic [31:0] busWdata,
  input logic        doneEvt,
  input logic        txAvail,
  input logic        rxRoom,
  input logic [31:0] statusVec
);
  // R2: a byte write always leaves the transmit FIFO non-empty
  a_r2_byte_write_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == AddrTxByte && !softRst) |=> txAvail);

  // R3: a byte read always leaves room in the receive FIFO
  a_r3_byte_read_room: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == AddrRxByte && !softRst) |=> rxRoom);

  // R6: clearing the illegal-access bit takes effect
  a_r6_clear_illegal: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == AddrClear && busWdata[BitIllegal]) |=> !statusVec[BitIllegal]);

  // R7: a done pulse sets the done bit
  a_r7_done_sets: assert property (@(posedge clk) disable iff (!rstN)
    (doneEvt && !softRst) |=> statusVec[BitDone]);

  // R7: the done bit holds until it is cleared
  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec[BitDone] && !softRst &&
     !(busWr && busAddr == AddrClear && busWdata[BitDone])) |=> statusVec[BitDone]);

  // R9: a soft reset empties both FIFOs and zeroes the status register
  a_r9_flush: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!txAvail && rxRoom && statusVec == 32'h0));
endmodule

bind dwf_top dwf_checker u_chk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .busWr(busWr), .busRd(busRd),
  .busAddr(busAddr), .busWdata(busWdata), .doneEvt(doneEvt),
  .txAvail(txAvail), .rxRoom(rxRoom), .statusVec(statusVec)
);

// File: tb/dwf_top_tb.sv
module dwf_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busAddr = 8'h0;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic        txPop = 1'b0;
  logic [7:0]  txByte;
  logic        txAvail;
  logic        rxPush = 1'b0;
  logic [7:0]  rxByte = 8'h0;
  logic        rxRoom;
  logic        doneEvt = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] TXW = 8'h20, TXB = 8'h24, RXW = 8'h28, RXB = 8'h2C;
  localparam logic [7:0] STA = 8'h30, ENA = 8'h34, CLR = 8'h38;

  always #5 clk = ~clk;

  dwf_top u_dut (
    .clk(clk), .rstN(rstN), .softRst(softRst), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .txPop(txPop), .txByte(txByte), .txAvail(txAvail),
    .rxPush(rxPush), .rxByte(rxByte), .rxRoom(rxRoom),
    .doneEvt(doneEvt), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] b);
    @(negedge clk);
    rxPush = 1'b1; rxByte = b;
    @(posedge clk); #1;
    rxPush = 1'b0;
  endtask

  task automatic popTx(output logic [7:0] b);
    @(negedge clk);
    b = txByte; txPop = 1'b1;
    @(posedge clk); #1;
    txPop = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk); doneEvt = 1'b1;
    @(posedge clk); #1; doneEvt = 1'b0;
  endtask

  task automatic pulseSoft();
    @(negedge clk); softRst = 1'b1;
    @(posedge clk); #1; softRst = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    busRead(STA, d); check("R11 status after reset", d, 32'h3);
    busRead(ENA, d); check("R11 enable after reset", d, 32'h0);
    check("R11 irq low", {31'h0, irq}, 32'h0);
    check("R11 txAvail low", {31'h0, txAvail}, 32'h0);
    check("R11 rxRoom high", {31'h0, rxRoom}, 32'h1);
  endtask

  task automatic t_txWord();
    logic [7:0] b;
    logic [7:0] exp [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    busWrite(TXW, 32'h4433_2211);
    busWrite(TXB, 32'h0000_AB55);
    for (int i = 0; i < 5; i++) begin
      popTx(b);
      check(i == 4 ? "R2 byte window low bits" : "R1 word byte order", {24'h0, b}, {24'h0, exp[i]});
    end
    check("R10 txAvail after drain", {31'h0, txAvail}, 32'h0);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    for (int i = 0; i < 5; i++) pushRx(8'hA0 + 8'(i));
    busRead(RXW, d); check("R3 word read order", d, 32'hA3A2_A1A0);
    busRead(RXB, d); check("R3 byte read", d, 32'h0000_00A4);
  endtask

  task automatic t_illegal();
    logic [31:0] d;
    logic [7:0]  b;
    int bad;
    busWrite(CLR, 32'hFFFF_FFFF);
    busRead(RXW, d); check("R4 empty word read returns 0", d, 32'h0);
    idle(1);
    busRead(STA, d); check("R4 illegal flag set", d & 32'h1000, 32'h1000);
    busWrite(CLR, 32'h0000_1000);
    busRead(STA, d); check("R6 illegal flag cleared", d & 32'h1000, 32'h0);
    pushRx(8'h5A); pushRx(8'hC3); idle(1);
    busRead(RXW, d); check("R4 short word read returns 0", d, 32'h0);
    busRead(RXB, d); check("R4 dropped read kept data", d, 32'h5A);
    busRead(RXB, d); check("R3 second byte", d, 32'hC3);
    for (int k = 0; k < 16; k++)
      busWrite(TXW, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    busWrite(CLR, 32'hFFFF_FFFF); idle(1);
    busRead(STA, d); check("R5 tx full and half", d, 32'h0000_000C);
    busWrite(TXB, 32'h99); idle(1);
    busRead(STA, d); check("R4 write to full tx", d, 32'h0000_100C);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      popTx(b);
      if (b != 8'(i)) bad++;
    end
    check("R1 full drain order mismatches", bad, 0);
    check("R4 dropped byte absent", {31'h0, txAvail}, 32'h0);
  endtask

  task automatic t_rxLevels();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) pushRx(8'(i));
    busWrite(CLR, 32'hFFFF_FFFF); idle(1);
    busRead(STA, d); check("R5 three rx bytes", d, 32'h0000_0803);
    for (int i = 0; i < 3; i++) busRead(RXB, d);
    for (int i = 0; i < 32; i++) pushRx(8'(i));
    busWrite(CLR, 32'hFFFF_FFFF); idle(1);
    busRead(STA, d); check("R5 rx half level", d, 32'h0000_08E3);
    for (int k = 0; k < 8; k++) busRead(RXW, d);
    check("R3 last word", d, 32'h1F1E_1D1C);
    idle(1);
    busRead(STA, d); check("R6 sticky after drain", d, 32'h0000_08E3);
    busWrite(CLR, 32'hFFFF_FFFF); idle(1);
    busRead(STA, d); check("R6 gone bits stay clear", d, 32'h0000_0003);
  endtask

  task automatic t_done();
    logic [31:0] d;
    busWrite(CLR, 32'hFFFF_FFFF);
    pulseDone();
    busRead(STA, d); check("R7 done set", d, 32'h0000_0203);
    idle(3);
    busRead(STA, d); check("R7 done held", d, 32'h0000_0203);
    busWrite(CLR, 32'h0000_0200);
    busRead(STA, d); check("R7 done cleared", d, 32'h0000_0003);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    busWrite(ENA, 32'hFFFF_FFFF);
    busRead(ENA, d); check("R8 enable mask", d, 32'h0000_1BEF);
    check("R8 irq with tx empty enabled", {31'h0, irq}, 32'h1);
    busWrite(ENA, 32'h0000_0200);
    busWrite(CLR, 32'hFFFF_FFFF); idle(1);
    check("R8 irq low when unenabled bits", {31'h0, irq}, 32'h0);
    pulseDone();
    check("R8 irq on enabled done", {31'h0, irq}, 32'h1);
    busWrite(CLR, 32'h0000_0200);
    check("R8 irq drops after clear", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    busWrite(TXW, 32'h0102_0304);
    pushRx(8'h11); idle(1);
    pulseSoft();
    busRead(STA, d); check("R9 status zero", d, 32'h0);
    check("R9 tx emptied", {31'h0, txAvail}, 32'h0);
    check("R9 rx room", {31'h0, rxRoom}, 32'h1);
    busRead(ENA, d); check("R9 enable kept", d, 32'h0000_0200);
    busRead(STA, d); check("R9 level bits return", d, 32'h0000_0003);
    busRead(RXB, d); check("R9 rx emptied", d, 32'h0);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    logic [7:0]  b;
    popTx(b);
    busWrite(TXB, 32'h77);
    #1 check("R10 empty pop ignored", {24'h0, txByte}, 32'h77);
    popTx(b);
    for (int i = 0; i < 64; i++) pushRx(8'(i));
    check("R10 rxRoom low when full", {31'h0, rxRoom}, 32'h0);
    pushRx(8'hEE);
    for (int k = 0; k < 16; k++) busRead(RXW, d);
    check("R10 last word before overflow", d, 32'h3F3E_3D3C);
    check("R10 rxRoom after drain", {31'h0, rxRoom}, 32'h1);
    busRead(RXB, d); check("R10 overflow byte dropped", d, 32'h0);
  endtask

  initial begin
    #200_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    idle(2);
    t_reset();
    t_txWord();
    t_rx();
    t_illegal();
    t_rxLevels();
    t_done();
    t_irq();
    t_soft();
    t_edges();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule